// File: doc/BRIEF.md
# Forward-Direction Extended-Capability Parallel Transmitter

This block sends bytes to a peripheral over an 8-bit parallel bus using the forward-direction extended-capability handshake. The host places bytes into a queue through one of two write paths. One path is for plain data. The other is for command bytes. Every queue entry keeps a tag that records which path it came through. The queue is shared by both paths and holds 16 entries by default. The host can see whether the queue is full or empty. A write that arrives while the queue is full is lost, and a sticky overflow flag records the loss.

A sequencer takes the oldest entry and places its byte on the bus. It sets the auto-feed line from the entry's tag: high for data, low for a command. After a setup time it pulls the strobe low and waits for the peripheral to raise Busy. It then releases the strobe and waits for Busy to fall before it takes the next entry. The peripheral reads the top bit of a command byte: 0 means a run-length count and 1 means a channel address. To send compressed data, the host writes the repeat count through the command path and then the byte through the data path. When the direction input selects reverse, no new transfer starts, but the queue keeps its contents.

Top module: `ecp_fwd_tx`

## Requirements
- R1: After reset, fifo_empty=1, fifo_full=0, overflow=0, n_strobe=1 and n_autofd=1.
- R2: A one-cycle pulse on wr_data_en or wr_cmd_en stores one entry. fifo_empty falls after the first entry is stored. fifo_full rises once 16 entries are held and none has been sent.
- R3: A write while fifo_full=1 is dropped. It leaves the queued contents unchanged and sets overflow. overflow stays 1 until reset.
- R4: While dir_rev=1, no transfer starts and n_strobe stays high. The stored entries are kept and are sent once dir_rev returns to 0.
- R5: Entries reach the bus in the order they were written, whichever path each one came through.
- R6: During a transfer, n_autofd is 1 for an entry written as data and 0 for an entry written as a command. n_autofd and pd are already at their transfer values in the cycle before n_strobe falls.
- R7: pd equals the written byte, and pd and n_autofd stay constant from the fall of n_strobe until Busy returns low.
- R8: n_strobe falls only after a setup cycle and only while Busy is low. It rises only after Busy has been seen high. The next entry is not started until Busy has been seen low again.
- R9: Command bytes go out unchanged. A count (bit 7 = 0) followed by a data byte reaches the peripheral as that pair, in that order. A channel address (bit 7 = 1) keeps its bit 7.
- R10: If wr_cmd_en and wr_data_en are high in the same cycle, only one entry is stored, tagged as a command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_data_en | input | 1 | Write wr_byte as a data entry |
| wr_cmd_en | input | 1 | Write wr_byte as a command entry (count or channel address) |
| wr_byte | input | 8 | Byte to be written |
| dir_rev | input | 1 | 1 = reverse direction, new transfers are held off |
| fifo_full | output | 1 | Queue holds 16 entries |
| fifo_empty | output | 1 | Queue holds no entries |
| overflow | output | 1 | Sticky: a write was dropped because the queue was full |
| pd | output | 8 | Parallel data bus to the peripheral |
| n_strobe | output | 1 | Active-low strobe |
| n_autofd | output | 1 | High for a data byte, low for a command byte |
| busy | input | 1 | Peripheral acknowledge |

## Verification
The assertions assume that the peripheral follows the handshake. It raises Busy only while the strobe is low, and it drops Busy only after the strobe has been released. Busy is only relied on once it has passed through the synchronizer. The bench peripheral model obeys these rules at every delay it is given. It drives Busy on the falling clock edge, and the host writes are driven on the same edge. Only the R10 scenario raises both write enables together. The other scenarios give each write a single one-cycle pulse.

// File: rtl/ecp_tx_pkg.sv
package ecp_tx_pkg;
   typedef struct packed {
      logic       is_cmd;
      logic [7:0] val;
   } ecp_entry_t;

   typedef enum logic [1:0] {
      HS_IDLE,
      HS_SETUP,
      HS_STROBE,
      HS_RELEASE
   } hs_state_t;
endpackage

// File: rtl/ecp_tx_fifo.sv
module ecp_tx_fifo #(
   parameter int DEPTH = 16,
   parameter int WIDTH = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] din,
   input  logic             pop,
   output logic [WIDTH-1:0] dout,
   output logic             full,
   output logic             empty
);
   localparam int AW = $clog2(DEPTH);
   localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

   initial begin
      if (DEPTH < 2 || (1 << AW) != DEPTH)
         $error("ecp_tx_fifo: DEPTH must be a power of two, at least 2");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wr_ptr, rd_ptr;
   logic [AW:0]      cnt;
   logic             do_push, do_pop;

   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign full    = (cnt == FULL_CNT);
   assign empty   = (cnt == '0);
   assign dout    = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + 1'b1;
         if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   // R3: a full queue that is not read stays full, so nothing is overwritten
   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !pop) |=> full);
   // R2: the two flags are never set together
   p_flags_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({full, empty}));
   // R5: the sequencer only reads when an entry is present
   p_pop_nonempty_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);
endmodule

// File: rtl/ecp_tx_hs.sv
module ecp_tx_hs
   import ecp_tx_pkg::*;
#(
   parameter int SYNC_STAGES  = 2,
   parameter int SETUP_CYCLES = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       have_entry,
   input  ecp_entry_t head,
   input  logic       dir_rev,
   input  logic       busy,
   output logic       pop,
   output logic [7:0] pd,
   output logic       n_strobe,
   output logic       n_autofd
);
   localparam int CW = (SETUP_CYCLES > 1) ? $clog2(SETUP_CYCLES) : 1;
   localparam logic [CW-1:0] SETUP_LAST = CW'(SETUP_CYCLES - 1);

   initial begin
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4)
         $error("ecp_tx_hs: SYNC_STAGES must be in 0..4");
      if (SETUP_CYCLES < 1)
         $error("ecp_tx_hs: SETUP_CYCLES must be at least 1");
   end

   logic busy_s;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign busy_s = busy;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sh;
         always_ff @(posedge clk) begin
            if (!rst_n) sh <= '0;
            else        sh <= {sh[SYNC_STAGES-2+1-1:0], busy} >> 0;
         end
         assign busy_s = sh[SYNC_STAGES-1];
      end
   endgenerate

   hs_state_t     state;
   logic [CW-1:0] setup_cnt;
   logic [7:0]    pd_q;
   logic          autofd_q;

   assign pop      = (state == HS_IDLE) && have_entry && !dir_rev;
   assign n_strobe = (state != HS_STROBE);
   assign pd       = pd_q;
   assign n_autofd = autofd_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= HS_IDLE;
         setup_cnt <= '0;
         pd_q      <= '0;
         autofd_q  <= 1'b1;
      end else begin
         case (state)
            HS_IDLE: begin
               if (pop) begin
                  pd_q      <= head.val;
                  autofd_q  <= !head.is_cmd;
                  setup_cnt <= '0;
                  state     <= HS_SETUP;
               end
            end
            HS_SETUP: begin
               if (setup_cnt == SETUP_LAST && !busy_s) state <= HS_STROBE;
               else if (setup_cnt != SETUP_LAST) setup_cnt <= setup_cnt + 1'b1;
            end
            HS_STROBE: begin
               if (busy_s) state <= HS_RELEASE;
            end
            HS_RELEASE: begin
               if (!busy_s) state <= HS_IDLE;
            end
            default: state <= HS_IDLE;
         endcase
      end
   end

   // R7: bus and tag hold for the whole transfer once it has begun
   p_hold_bus_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state != HS_IDLE && $past(state) != HS_IDLE) |-> ($stable(pd) && $stable(n_autofd)));
   // R8: strobe is released only after Busy was seen high
   p_rise_after_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(n_strobe) |-> $past(busy_s));
   // R8: strobe falls only out of the setup phase
   p_fall_after_setup_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(n_strobe) |-> $past(state) == HS_SETUP);
   // R4: reverse direction keeps the sequencer idle
   p_no_start_rev_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == HS_IDLE && dir_rev) |=> state == HS_IDLE);
endmodule

// File: rtl/ecp_fwd_tx.sv
module ecp_fwd_tx
   import ecp_tx_pkg::*;
#(
   parameter int DEPTH        = 16,
   parameter int SYNC_STAGES  = 2,
   parameter int SETUP_CYCLES = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_data_en,
   input  logic       wr_cmd_en,
   input  logic [7:0] wr_byte,
   input  logic       dir_rev,
   output logic       fifo_full,
   output logic       fifo_empty,
   output logic       overflow,
   output logic [7:0] pd,
   output logic       n_strobe,
   output logic       n_autofd,
   input  logic       busy
);
   localparam int EW = $bits(ecp_entry_t);

   ecp_entry_t wr_entry, head;
   logic [EW-1:0] head_raw;
   logic wr_any, pop, ovf_q;

   assign wr_any          = wr_data_en || wr_cmd_en;
   assign wr_entry.is_cmd = wr_cmd_en;
   assign wr_entry.val    = wr_byte;
   assign head            = ecp_entry_t'(head_raw);
   assign overflow        = ovf_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                   ovf_q <= 1'b0;
      else if (wr_any && fifo_full) ovf_q <= 1'b1;
   end

   ecp_tx_fifo #(.DEPTH(DEPTH), .WIDTH(EW)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (wr_any),
      .din   (wr_entry),
      .pop   (pop),
      .dout  (head_raw),
      .full  (fifo_full),
      .empty (fifo_empty)
   );

   ecp_tx_hs #(.SYNC_STAGES(SYNC_STAGES), .SETUP_CYCLES(SETUP_CYCLES)) u_hs (
      .clk        (clk),
      .rst_n      (rst_n),
      .have_entry (!fifo_empty),
      .head       (head),
      .dir_rev    (dir_rev),
      .busy       (busy),
      .pop        (pop),
      .pd         (pd),
      .n_strobe   (n_strobe),
      .n_autofd   (n_autofd)
   );

   // R3: overflow is sticky until reset
   p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |=> overflow);
   // R3: overflow only rises on a write that meets a full queue
   p_ovf_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overflow) |-> $past(fifo_full && wr_any));
endmodule

// File: tb/tb_ecp_fwd_tx.sv
module tb_ecp_fwd_tx;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_data_en = 1'b0, wr_cmd_en = 1'b0, dir_rev = 1'b0, busy = 1'b0;
   logic [7:0] wr_byte = '0;
   logic       fifo_full, fifo_empty, overflow, n_strobe, n_autofd;
   logic [7:0] pd;

   always #10 clk = ~clk;

   ecp_fwd_tx dut (
      .clk(clk), .rst_n(rst_n), .wr_data_en(wr_data_en), .wr_cmd_en(wr_cmd_en),
      .wr_byte(wr_byte), .dir_rev(dir_rev), .fifo_full(fifo_full),
      .fifo_empty(fifo_empty), .overflow(overflow), .pd(pd),
      .n_strobe(n_strobe), .n_autofd(n_autofd), .busy(busy)
   );

   int tests = 0, fails = 0;
   logic [8:0] rx_log [0:63];
   int rx_n = 0;
   int resp_dly = 1, hold_dly = 1;
   int p_st = 0, p_cnt = 0;
   int hold_err = 0, strobe_err = 0, setup_err = 0;
   logic [7:0] snap_pd, prev_pd = '0;
   logic snap_af, prev_af = 1'b1, prev_ns = 1'b1;

   // peripheral model
   always @(negedge clk) begin
      if (!rst_n) begin
         busy = 1'b0; p_st = 0; p_cnt = 0;
      end else begin
         if (prev_ns && !n_strobe) begin
            if (busy) strobe_err++;
            if (pd != prev_pd || n_autofd != prev_af) setup_err++;
         end
         if (p_st == 0) begin
            if (!n_strobe) begin
               if (p_cnt >= resp_dly) begin
                  busy = 1'b1;
                  snap_pd = pd; snap_af = n_autofd;
                  if (rx_n < 64) rx_log[rx_n] = {!n_autofd, pd};
                  rx_n++;
                  p_cnt = 0; p_st = 1;
               end else p_cnt++;
            end
         end else begin
            if (pd != snap_pd || n_autofd != snap_af) hold_err++;
            if (n_strobe) begin
               if (p_cnt >= hold_dly) begin
                  busy = 1'b0; p_cnt = 0; p_st = 0;
               end else p_cnt++;
            end
         end
      end
      prev_ns = n_strobe; prev_pd = pd; prev_af = n_autofd;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input bit cmd, input logic [7:0] b);
      @(negedge clk);
      wr_cmd_en = cmd; wr_data_en = !cmd; wr_byte = b;
      @(negedge clk);
      wr_cmd_en = 1'b0; wr_data_en = 1'b0;
   endtask

   task automatic wait_rx(input int n);
      for (int i = 0; i < 2000 && rx_n < n; i++) @(posedge clk);
      repeat (20) @(posedge clk);
   endtask

   task automatic do_reset;
      @(negedge clk); rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1; rx_n = 0;
      @(posedge clk); #1;
   endtask

   task automatic t_reset;
      chk(fifo_empty == 1'b1, "R1 empty", fifo_empty, 1);
      chk(fifo_full == 1'b0, "R1 full", fifo_full, 0);
      chk(overflow == 1'b0, "R1 overflow", overflow, 0);
      chk(n_strobe == 1'b1 && n_autofd == 1'b1, "R1 strobe/autofd",
          {n_strobe, n_autofd}, 3);
   endtask

   task automatic t_rle;
      int base = rx_n;
      logic [8:0] exp [4] = '{9'h105, 9'h0A5, 9'h183, 9'h03C};
      wr(1, 8'h05); wr(0, 8'hA5); wr(1, 8'h83); wr(0, 8'h3C);
      wait_rx(base + 4);
      chk(rx_n == base + 4, "R9 count", rx_n - base, 4);
      for (int i = 0; i < 4; i++)
         chk(rx_log[base+i] == exp[i], "R9 order/tag (R6)", rx_log[base+i], exp[i]);
      chk(rx_log[base][7] == 1'b0 && rx_log[base+2][7] == 1'b1, "R9 bit7",
          {rx_log[base][7], rx_log[base+2][7]}, 1);
   endtask

   task automatic t_slow;
      int base = rx_n;
      resp_dly = 4; hold_dly = 6;
      wr(0, 8'h11); wr(0, 8'h22); wr(1, 8'h33);
      wait_rx(base + 3);
      chk(rx_n == base + 3, "R8 count", rx_n - base, 3);
      chk(rx_log[base+1] == 9'h022 && rx_log[base+2] == 9'h133, "R5 order slow",
          rx_log[base+2], 9'h133);
      chk(strobe_err == 0, "R8 strobe fell while busy", strobe_err, 0);
      chk(hold_err == 0, "R7 bus held", hold_err, 0);
      chk(setup_err == 0, "R6 setup before strobe", setup_err, 0);
      resp_dly = 1; hold_dly = 1;
   endtask

   task automatic t_simul;
      int base = rx_n;
      @(negedge clk);
      wr_cmd_en = 1'b1; wr_data_en = 1'b1; wr_byte = 8'h42;
      @(negedge clk);
      wr_cmd_en = 1'b0; wr_data_en = 1'b0;
      wait_rx(base + 1);
      chk(rx_n == base + 1, "R10 one entry", rx_n - base, 1);
      chk(rx_log[base] == 9'h142, "R10 tagged command", rx_log[base], 9'h142);
   endtask

   task automatic t_fill;
      int base = rx_n;
      logic [8:0] e;
      @(negedge clk); dir_rev = 1'b1;
      wr(0, 8'h00);
      @(posedge clk); #1;
      chk(fifo_empty == 1'b0, "R2 empty falls", fifo_empty, 0);
      for (int i = 1; i < 16; i++) wr(i % 4 == 0, 8'(i * 7));
      @(posedge clk); #1;
      chk(fifo_full == 1'b1, "R2 full at 16", fifo_full, 1);
      chk(overflow == 1'b0, "R3 no overflow yet", overflow, 0);
      wr(0, 8'hEE);
      @(posedge clk); #1;
      chk(overflow == 1'b1, "R3 overflow set", overflow, 1);
      repeat (10) @(posedge clk); #1;
      chk(n_strobe == 1'b1 && rx_n == base, "R4 held off", rx_n - base, 0);
      @(negedge clk); dir_rev = 1'b0;
      wait_rx(base + 17);
      chk(rx_n == base + 16, "R3 dropped write absent", rx_n - base, 16);
      for (int i = 0; i < 16; i++) begin
         e = {i % 4 == 0 && i != 0, 8'(i * 7)};
         chk(rx_log[base+i] == e, "R5 order after release", rx_log[base+i], e);
      end
      chk(fifo_empty == 1'b1 && overflow == 1'b1, "R3 sticky", overflow, 1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      do_reset();
      t_reset();
      t_rle();
      t_slow();
      t_simul();
      t_fill();
      do_reset();
      chk(overflow == 1'b0, "R3 cleared by reset", overflow, 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule